// File: doc/BRIEF.md
# Upstream Minislot Reservation Requester

This block controls upstream access for a subscriber unit on a shared, time-slotted medium. The upstream channel is cut into minislots. A packet on it must fill one or more consecutive minislots. The host offers a packet length. The block turns that length into a minislot count and places a reservation request in the next contention opportunity. It then waits for a grant that names the first reserved minislot. At that minislot it raises transmit enable for exactly the requested number of minislots.

Slot timing comes from a minislot boundary strobe and a running minislot number taken from the downstream side. A constant ranging offset, measured elsewhere, is added to that number, so the block works in corrected upstream time. A request can go unanswered, for example after a collision in the contention slot. The block then counts as failed any request whose grant does not arrive within a fixed number of minislots. It skips a random number of request opportunities and tries again, and the random window doubles after each failure. If the host offers a second packet while the first is waiting for its slot, that packet's minislot count is carried in the header field of the outgoing transmission. The second packet then waits for its grant directly, with no contention request of its own.

Top module: `ups_resv_req`

## Requirements
- R1: After reset, host_ready is 1 and req_out, tx_en, host_done and host_err are all 0.
- R2: The minislot count is ceil(host_len / SLOT_BYTES), and a length of 0 counts as one minislot. req_cnt carries this count during the request pulse (SLOT_BYTES = 16 by default).
- R3: A request is a one-cycle pulse on req_out. It appears in the cycle after a clock edge that saw slot_strobe and req_opp both high. A boundary with req_opp low is never used for a request.
- R4: After a grant, tx_en rises in the cycle after the boundary whose corrected slot, (slot_num + range_ofs) mod 2^SLOT_W, equals grant_start.
- R5: tx_en stays high without a gap for exactly the granted count of minislots. It drops in the cycle after the boundary that ends the last of them.
- R6: A failure is counted when GRANT_TMO boundaries (8 by default) follow the request with no grant. No transmission happens after a failure.
- R7: After the k-th consecutive failure, the block skips N request opportunities before requesting again, where 0 <= N < min(2^k, WIN_MAX) and WIN_MAX = 1024. N comes from a free-running 16-bit LFSR masked to the window. With an opportunity at every boundary, the gap between requests is GRANT_TMO + N + 1 boundaries.
- R8: A received grant, and every newly accepted packet, returns the window to its minimum of 2.
- R9: After MAX_FAIL = 16 consecutive failures, the packet is dropped. host_err pulses for one cycle, no transmission takes place, and the block returns to idle.
- R10: host_done pulses for one cycle, in the cycle right after tx_en falls.
- R11: A packet accepted while the block waits for its granted slot has its minislot count shown on tx_piggy for the whole transmission. After host_done, the block waits for that packet's grant without issuing req_out. tx_piggy is 0 when nothing is pending or tx_en is low.
- R12: host_ready is 1 only when idle, or while waiting for a granted slot with no second packet pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host offers a packet |
| host_len | input | LEN_W | Packet length in bytes |
| host_ready | output | 1 | Block accepts a packet this cycle |
| host_done | output | 1 | Packet fully transmitted (pulse) |
| host_err | output | 1 | Packet dropped after too many failures (pulse) |
| slot_strobe | input | 1 | Minislot boundary |
| slot_num | input | SLOT_W | Downstream minislot number at this boundary |
| req_opp | input | 1 | This boundary opens a contention request opportunity |
| range_ofs | input | SLOT_W | Ranging correction added to slot_num |
| grant_valid | input | 1 | Grant for the outstanding request |
| grant_start | input | SLOT_W | First reserved minislot (corrected time) |
| req_out | output | 1 | Reservation request pulse |
| req_cnt | output | CNT_W | Minislots requested, valid with req_out |
| tx_en | output | 1 | Transmit enable |
| tx_piggy | output | CNT_W | Header field: minislots wanted for the next packet |

## Verification
Every result is registered once. req_out, the rise and fall of tx_en, host_done and host_err all appear in the cycle right after the clock edge that saw the causing boundary or grant. The bench drives slot boundaries at the falling edge and its own stimulus three quarters into the cycle. It samples every output one nanosecond after the rising edge, so each sample sees the result together with the boundary inputs that caused it. Timeout and backoff are checked by counting boundaries between request pulses. Each gap is then compared against the timeout plus the window bound for that failure count.

// File: rtl/urr_pkg.sv
package urr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SIZE  = 3'd1,
        ST_REQ   = 3'd2,
        ST_WGNT  = 3'd3,
        ST_BOFF  = 3'd4,
        ST_WSLOT = 3'd5,
        ST_TX    = 3'd6,
        ST_DONE  = 3'd7
    } urr_st_e;

endpackage

// File: rtl/urr_sizer.sv
module urr_sizer #(
    parameter int LEN_W      = 11,
    parameter int SLOT_BYTES = 16,
    parameter int CNT_W      = 8
) (
    input  logic [LEN_W-1:0] len,
    output logic [CNT_W-1:0] cnt
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] sum_w;

    always_comb begin
        sum_w = {1'b0, len} + SUM_W'(SLOT_BYTES - 1);
        if (len == '0) begin
            cnt = CNT_W'(1);
        end else begin
            cnt = CNT_W'(sum_w / SUM_W'(SLOT_BYTES));
        end
    end
endmodule

// File: rtl/urr_lfsr.sv
module urr_lfsr #(
    parameter int          OUT_W = 11,
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter logic [15:0] TAPS  = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [15:0] state_d, state_q;

    always_comb begin
        state_d = {1'b0, state_q[15:1]} ^ (state_q[0] ? TAPS : 16'h0000);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/urr_slot_align.sv
module urr_slot_align #(
    parameter int SLOT_W = 8
) (
    input  logic              slot_strobe,
    input  logic [SLOT_W-1:0] slot_num,
    input  logic [SLOT_W-1:0] range_ofs,
    input  logic [SLOT_W-1:0] target,
    output logic              hit
);
    logic [SLOT_W-1:0] corrected;

    always_comb begin
        corrected = slot_num + range_ofs;
        hit       = slot_strobe && (corrected == target);
    end
endmodule

// File: rtl/ups_resv_req.sv
module ups_resv_req
    import urr_pkg::*;
#(
    parameter int          LEN_W      = 11,
    parameter int          SLOT_BYTES = 16,
    parameter int          SLOT_W     = 8,
    parameter int          GRANT_TMO  = 8,
    parameter int          WIN_MIN    = 2,
    parameter int          WIN_MAX    = 1024,
    parameter int          MAX_FAIL   = 16,
    parameter logic [15:0] LFSR_SEED  = 16'hACE1,
    parameter int          CNT_W      = LEN_W - $clog2(SLOT_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [LEN_W-1:0]  host_len,
    output logic              host_ready,
    output logic              host_done,
    output logic              host_err,
    input  logic              slot_strobe,
    input  logic [SLOT_W-1:0] slot_num,
    input  logic              req_opp,
    input  logic [SLOT_W-1:0] range_ofs,
    input  logic              grant_valid,
    input  logic [SLOT_W-1:0] grant_start,
    output logic              req_out,
    output logic [CNT_W-1:0]  req_cnt,
    output logic              tx_en,
    output logic [CNT_W-1:0]  tx_piggy
);
    localparam int TMO_W  = $clog2(GRANT_TMO + 1);
    localparam int WIN_W  = $clog2(WIN_MAX) + 1;
    localparam int FAIL_W = $clog2(MAX_FAIL + 1);

    typedef struct packed {
        urr_st_e            st;
        logic [LEN_W-1:0]   len;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   rem;
        logic [SLOT_W-1:0]  start;
        logic [TMO_W-1:0]   tmo;
        logic [WIN_W-1:0]   win;
        logic [WIN_W-1:0]   bo;
        logic [FAIL_W-1:0]  fails;
        logic               nxt_pend;
        logic [CNT_W-1:0]   nxt_cnt;
        logic               req;
        logic               tx;
        logic               done;
        logic               err;
    } urr_regs_t;

    urr_regs_t cur_q, nxt_d;

    logic [CNT_W-1:0] size_cur;
    logic [CNT_W-1:0] size_nxt;
    logic [WIN_W-1:0] rnd_bits;
    logic             slot_hit;
    logic             opp_now;

    urr_sizer #(
        .LEN_W      (LEN_W),
        .SLOT_BYTES (SLOT_BYTES),
        .CNT_W      (CNT_W)
    ) u_size_cur (
        .len (cur_q.len),
        .cnt (size_cur)
    );

    urr_sizer #(
        .LEN_W      (LEN_W),
        .SLOT_BYTES (SLOT_BYTES),
        .CNT_W      (CNT_W)
    ) u_size_nxt (
        .len (host_len),
        .cnt (size_nxt)
    );

    urr_lfsr #(
        .OUT_W (WIN_W),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd_bits)
    );

    urr_slot_align #(
        .SLOT_W (SLOT_W)
    ) u_align (
        .slot_strobe (slot_strobe),
        .slot_num    (slot_num),
        .range_ofs   (range_ofs),
        .target      (cur_q.start),
        .hit         (slot_hit)
    );

    assign opp_now = slot_strobe && req_opp;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.req  = 1'b0;
        nxt_d.done = 1'b0;
        nxt_d.err  = 1'b0;

        case (cur_q.st)
            ST_IDLE: begin
                if (host_valid) begin
                    nxt_d.len   = host_len;
                    nxt_d.win   = WIN_W'(WIN_MIN);
                    nxt_d.fails = '0;
                    nxt_d.st    = ST_SIZE;
                end
            end
            ST_SIZE: begin
                nxt_d.cnt = size_cur;
                nxt_d.st  = ST_REQ;
            end
            ST_REQ: begin
                if (opp_now) begin
                    nxt_d.req = 1'b1;
                    nxt_d.tmo = '0;
                    nxt_d.st  = ST_WGNT;
                end
            end
            ST_WGNT: begin
                if (grant_valid) begin
                    nxt_d.start = grant_start;
                    nxt_d.win   = WIN_W'(WIN_MIN);
                    nxt_d.fails = '0;
                    nxt_d.st    = ST_WSLOT;
                end else if (slot_strobe) begin
                    if (cur_q.tmo == TMO_W'(GRANT_TMO - 1)) begin
                        if (cur_q.fails == FAIL_W'(MAX_FAIL - 1)) begin
                            nxt_d.err = 1'b1;
                            nxt_d.st  = ST_DONE;
                        end else begin
                            nxt_d.fails = cur_q.fails + FAIL_W'(1);
                            nxt_d.bo    = rnd_bits & (cur_q.win - WIN_W'(1));
                            if (cur_q.win < WIN_W'(WIN_MAX)) begin
                                nxt_d.win = cur_q.win << 1;
                            end
                            nxt_d.st = ST_BOFF;
                        end
                    end else begin
                        nxt_d.tmo = cur_q.tmo + TMO_W'(1);
                    end
                end
            end
            ST_BOFF: begin
                if (cur_q.bo == '0) begin
                    nxt_d.st = ST_REQ;
                end else if (opp_now) begin
                    nxt_d.bo = cur_q.bo - WIN_W'(1);
                end
            end
            ST_WSLOT: begin
                if (host_valid && !cur_q.nxt_pend) begin
                    nxt_d.nxt_pend = 1'b1;
                    nxt_d.nxt_cnt  = size_nxt;
                end
                if (slot_hit) begin
                    nxt_d.rem = cur_q.cnt;
                    nxt_d.st  = ST_TX;
                end
            end
            ST_TX: begin
                if (slot_strobe) begin
                    if (cur_q.rem == CNT_W'(1)) begin
                        nxt_d.done = 1'b1;
                        nxt_d.st   = ST_DONE;
                    end else begin
                        nxt_d.rem = cur_q.rem - CNT_W'(1);
                    end
                end
            end
            ST_DONE: begin
                if (cur_q.nxt_pend) begin
                    nxt_d.cnt      = cur_q.nxt_cnt;
                    nxt_d.nxt_pend = 1'b0;
                    nxt_d.tmo      = '0;
                    nxt_d.win      = WIN_W'(WIN_MIN);
                    nxt_d.fails    = '0;
                    nxt_d.st       = ST_WGNT;
                end else begin
                    nxt_d.st = ST_IDLE;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase

        nxt_d.tx = (nxt_d.st == ST_TX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign host_ready = (cur_q.st == ST_IDLE) ||
                        ((cur_q.st == ST_WSLOT) && !cur_q.nxt_pend);
    assign host_done  = cur_q.done;
    assign host_err   = cur_q.err;
    assign req_out    = cur_q.req;
    assign req_cnt    = cur_q.req ? cur_q.cnt : '0;
    assign tx_en      = cur_q.tx;
    assign tx_piggy   = (cur_q.tx && cur_q.nxt_pend) ? cur_q.nxt_cnt : '0;
endmodule

// File: rtl/urr_chk.sv
module urr_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_ready,
    input logic             host_done,
    input logic             host_err,
    input logic             slot_strobe,
    input logic             req_opp,
    input logic             req_out,
    input logic [CNT_W-1:0] req_cnt,
    input logic             tx_en,
    input logic [CNT_W-1:0] tx_piggy
);
    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_out |=> !req_out);

    assert_req_opp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_out |-> $past(slot_strobe && req_opp));

    assert_req_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_out |-> (req_cnt != '0));

    assert_tx_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(slot_strobe));

    assert_tx_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> $past(slot_strobe));

    assert_done_after_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> $past(tx_en));

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> !host_err);

    assert_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> (!tx_en && !host_done));

    assert_ready_no_tx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !tx_en);

    assert_piggy_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> $stable(tx_piggy));
endmodule

bind ups_resv_req urr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ready  (host_ready),
    .host_done   (host_done),
    .host_err    (host_err),
    .slot_strobe (slot_strobe),
    .req_opp     (req_opp),
    .req_out     (req_out),
    .req_cnt     (req_cnt),
    .tx_en       (tx_en),
    .tx_piggy    (tx_piggy)
);

// File: tb/tb_ups_resv_req.sv
`timescale 1ns/1ps
module tb_ups_resv_req;
    localparam int LEN_W = 11;
    localparam int SLOT_W = 8;
    localparam int CNT_W = 8;
    localparam int TMO = 8;
    localparam int PER = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_valid = 1'b0;
    logic [LEN_W-1:0] host_len = '0;
    logic host_ready, host_done, host_err;
    logic slot_strobe = 1'b0;
    logic [SLOT_W-1:0] slot_num = '0;
    logic req_opp;
    logic [SLOT_W-1:0] range_ofs = '0;
    logic grant_valid = 1'b0;
    logic [SLOT_W-1:0] grant_start = '0;
    logic req_out;
    logic [CNT_W-1:0] req_cnt;
    logic tx_en;
    logic [CNT_W-1:0] tx_piggy;
    logic opp_all = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int n_req = 0, n_done = 0, n_err = 0, n_rise = 0;
    int strobe_total = 0;
    int req_strobe [64];
    int last_req_cnt = 0;
    int rise_slot = 0;
    int tx_cycles = 0, last_tx_cycles = 0;
    logic ptx = 1'b0;

    assign req_opp = opp_all ? 1'b1 : (slot_num[0] == 1'b0);

    always #(PER/2) clk = ~clk;

    ups_resv_req dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_len(host_len),
        .host_ready(host_ready), .host_done(host_done), .host_err(host_err),
        .slot_strobe(slot_strobe), .slot_num(slot_num), .req_opp(req_opp),
        .range_ofs(range_ofs), .grant_valid(grant_valid), .grant_start(grant_start),
        .req_out(req_out), .req_cnt(req_cnt), .tx_en(tx_en), .tx_piggy(tx_piggy)
    );

    // stimulus vectors: len, ofs, gap (slots to granted start), expected count
    localparam logic [34:0] VEC [8] = '{
        {11'd1,    8'd0,   8'd3, 8'd1},
        {11'd16,   8'd0,   8'd4, 8'd1},
        {11'd17,   8'd5,   8'd3, 8'd2},
        {11'd32,   8'd250, 8'd6, 8'd2},
        {11'd100,  8'd17,  8'd2, 8'd7},
        {11'd2047, 8'd3,   8'd4, 8'd128},
        {11'd0,    8'd0,   8'd3, 8'd1},
        {11'd48,   8'd200, 8'd5, 8'd3}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // boundary generator: strobe every PER cycles, driven at the falling edge
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % PER;
            slot_strobe = (ph == PER - 1);
            if (ph == PER - 1) slot_num = slot_num + 1'b1;
        end
    end

    // monitor: 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (slot_strobe) strobe_total++;
            if (req_out) begin
                if (n_req < 64) req_strobe[n_req] = strobe_total;
                n_req++;
                last_req_cnt = int'(req_cnt);
                chk(slot_strobe && req_opp, "R3 request without opportunity", int'(slot_strobe), 1);
            end
            if (tx_en && !ptx) begin
                n_rise++;
                rise_slot = int'(slot_num);
                tx_cycles = 0;
            end
            if (tx_en) tx_cycles++;
            if (!tx_en && ptx) last_tx_cycles = tx_cycles;
            if (host_done) begin
                n_done++;
                chk(ptx && !tx_en, "R10 done not right after tx", int'(ptx), 1);
            end
            if (host_err) n_err++;
        end
        ptx = tx_en;
    end

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic send(input int len);
        logic r;
        host_len = LEN_W'(len);
        host_valid = 1'b1;
        while (1) begin
            r = host_ready;
            step();
            if (r) break;
        end
        host_valid = 1'b0;
    endtask

    task automatic grant(input int gap, output int exp_slot);
        exp_slot = (int'(slot_num) + gap) % 256;
        grant_start = SLOT_W'(int'(slot_num) + int'(range_ofs) + gap);
        grant_valid = 1'b1;
        step();
        grant_valid = 1'b0;
    endtask

    task automatic check_gap(input int k, input int fail_idx, input string tag);
        int gap, n, win;
        gap = req_strobe[k] - req_strobe[k-1];
        n = gap - TMO - 1;
        win = (fail_idx >= 10) ? 1024 : (1 << fail_idx);
        chk(n >= 0 && n < win, tag, n, win - 1);
    endtask

    initial begin
        int exp_slot, r0, d0, e0, t0;
        step();
        do_reset();
        // R1: reset state
        chk(host_ready === 1'b1, "R1 host_ready after reset", int'(host_ready), 1);
        chk(req_out === 1'b0 && tx_en === 1'b0, "R1 req/tx after reset", int'(tx_en), 0);
        chk(host_done === 1'b0 && host_err === 1'b0, "R1 done/err after reset", int'(host_err), 0);

        // vector loop: R2 R3 R4 R5 R10
        for (int i = 0; i < 8; i++) begin
            int vlen, vofs, vgap, vcnt, ecnt;
            vlen = int'(VEC[i][34:24]);
            vofs = int'(VEC[i][23:16]);
            vgap = int'(VEC[i][15:8]);
            vcnt = int'(VEC[i][7:0]);
            ecnt = (vlen == 0) ? 1 : (vlen + 15) / 16;
            chk(ecnt == vcnt, "R2 table self-check", vcnt, ecnt);
            opp_all = (i % 2 == 0);
            range_ofs = SLOT_W'(vofs);
            do_reset();
            r0 = n_req; d0 = n_done;
            send(vlen);
            wait (n_req == r0 + 1);
            step();
            chk(last_req_cnt == ecnt, "R2 req_cnt", last_req_cnt, ecnt);
            grant(vgap, exp_slot);
            wait (n_done == d0 + 1);
            step();
            chk(rise_slot == exp_slot, "R4 tx start slot", rise_slot, exp_slot);
            chk(last_tx_cycles == ecnt * PER, "R5 tx length cycles", last_tx_cycles, ecnt * PER);
            chk(host_ready === 1'b1, "R12 ready after done", int'(host_ready), 1);
        end

        // R6 R7: timeouts and backoff bounds
        opp_all = 1'b1;
        range_ofs = '0;
        do_reset();
        r0 = n_req; d0 = n_done; t0 = n_rise;
        send(40);
        wait (n_req == r0 + 4);
        step();
        chk(n_rise == t0, "R6 no tx after failures", n_rise - t0, 0);
        chk(req_strobe[r0+1] - req_strobe[r0] >= TMO + 1, "R6 timeout length",
            req_strobe[r0+1] - req_strobe[r0], TMO + 1);
        for (int k = 1; k <= 3; k++) check_gap(r0 + k, k, "R7 backoff window");
        grant(3, exp_slot);
        wait (n_done == d0 + 1);
        step();
        chk(last_tx_cycles == 3 * PER, "R5 tx after retries", last_tx_cycles, 3 * PER);

        // R8: window back to minimum
        r0 = n_req; d0 = n_done;
        send(10);
        wait (n_req == r0 + 2);
        step();
        check_gap(r0 + 1, 1, "R8 window reset to 2");
        grant(2, exp_slot);
        wait (n_done == d0 + 1);
        step();

        // R9: give up after 16 failures
        r0 = n_req; e0 = n_err; t0 = n_rise; d0 = n_done;
        send(64);
        wait (n_err == e0 + 1);
        step();
        chk(n_req - r0 == 16, "R9 requests before drop", n_req - r0, 16);
        chk(n_rise == t0 && n_done == d0, "R9 no tx on drop", n_rise - t0, 0);
        chk(host_ready === 1'b1, "R9 idle after drop", int'(host_ready), 1);
        for (int k = 1; k <= 15; k++) check_gap(r0 + k, k, "R7 doubling window");

        // R11 R12: piggyback request
        r0 = n_req; d0 = n_done;
        send(20);
        wait (n_req == r0 + 1);
        step();
        grant(6, exp_slot);
        chk(host_ready === 1'b1, "R12 ready while waiting slot", int'(host_ready), 1);
        send(50);
        chk(host_ready === 1'b0, "R12 not ready with pending", int'(host_ready), 0);
        wait (tx_en === 1'b1);
        step();
        chk(int'(tx_piggy) == 4, "R11 piggy field", int'(tx_piggy), 4);
        wait (n_done == d0 + 1);
        step();
        chk(last_tx_cycles == 2 * PER, "R5 first of pair", last_tx_cycles, 2 * PER);
        grant(3, exp_slot);
        wait (n_done == d0 + 2);
        step();
        chk(n_req == r0 + 1, "R11 no contention for piggy packet", n_req - r0, 1);
        chk(last_tx_cycles == 4 * PER, "R11 piggy packet length", last_tx_cycles, 4 * PER);
        chk(rise_slot == exp_slot, "R4 piggy start slot", rise_slot, exp_slot);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog (all) actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule